// File: doc/BRIEF.md
# Two-Ratio Fractional Clock-Enable Generator

This block derives a slow timing reference, typically close to 32.768 kHz, from a fast crystal clock of about 24 MHz. No single integer divider reaches that ratio closely enough. The block therefore alternates between two integer division ratios. It runs a set number of output periods at the first ratio and then a set number at the second. The average period then falls between the two ratios, weighted by the two repeat counts. A single-ratio mode and a pass-through mode are also offered.

The output is a one-cycle enable pulse in the input clock domain. The pulse marks the start of every divided period, so downstream logic runs on the fast clock and qualifies its work with the pulse. Two 32-bit configuration words are written and read through a simple port. The division and repeat fields are locked while the generator runs. Software stops the generator by clearing its enables, reprograms it, and then starts it again.

Top module: `fracdiv_clkgen`

## Requirements
- R1: Word 0 (select 0) holds the first divider field in bits [11:0], the second divider field in bits [23:12], the two-ratio enable in bit 28, the output enable in bit 30 and the input enable in bit 31. All other bits read as zero, and every bit is zero after reset.
- R2: Word 1 (select 1) holds the first repeat field in bits [11:0], the second repeat field in bits [23:12] and the pass-through enable in bit 24. All other bits read as zero, and every bit is zero after reset.
- R3: Every divider and repeat field means its value plus one. A divider field of 0 therefore gives a pulse on every cycle.
- R4: The generator runs only while both enable bits are set. Otherwise the pulse stays low. The first cycle after the write that sets the second enable carries a pulse.
- R5: With pass-through set while the generator runs, the pulse is high on every cycle. Pass-through takes precedence over the two-ratio mode.
- R6: With two-ratio mode clear, pulses repeat every (first divider field + 1) cycles, and the second divider field has no effect.
- R7: With two-ratio mode set, the sequence runs (first repeat + 1) periods of (first divider + 1) cycles, then (second repeat + 1) periods of (second divider + 1) cycles, and then repeats. It starts with the first ratio.
- R8: A change of ratio happens only at the end of a complete period. Every interval between pulses equals one of the two divider lengths. Two full sequences of the 733/732 with 8/11 setting span exactly 27832 cycles and contain 38 pulses.
- R9: While the generator runs, writes to word 1 are ignored. A write to word 0 changes only the two enable bits.
- R10: Stopping and restarting the generator restarts the sequence with a full period of the first ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_sel_i | input | 1 | Word select for writes (0 or 1) |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Word select for the combinational read |
| rd_data_o | output | 32 | Read data of the selected word |
| tick_o | output | 1 | One-cycle enable pulse at the start of each divided period |

## Verification
A wrong count or a misplaced ratio switch moves a pulse, and the comparison made every cycle shows it within one divider length. A wrong phase or repeat count keeps every interval legal but sends a wrong-length interval no later than the end of the first sequence (M1+M2 periods). A lock that leaks shows at once on readback of the word. A missing restart shows on the first interval after re-enable.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
  localparam int FIELD_W  = 12;
  localparam int REG_W    = 32;
  localparam int LEN_W    = FIELD_W + 1;
  // bit positions that software decodes
  localparam int LO_LSB   = 0;
  localparam int HI_LSB   = FIELD_W;
  localparam int DUAL_BIT = 28;
  localparam int OEN_BIT  = 30;
  localparam int IEN_BIT  = 31;
  localparam int BYP_BIT  = 24;

  typedef struct packed {
    logic               in_en;
    logic               out_en;
    logic               dual;
    logic               bypass;
    logic [FIELD_W-1:0] div_a;
    logic [FIELD_W-1:0] div_b;
    logic [FIELD_W-1:0] rep_a;
    logic [FIELD_W-1:0] rep_b;
  } fd_cfg_t;

  // programmed field -> effective count
  function automatic logic [LEN_W-1:0] eff_count(input logic [FIELD_W-1:0] f);
    return {1'b0, f} + LEN_W'(1);
  endfunction

  function automatic logic cfg_running(input fd_cfg_t c);
    return c.in_en & c.out_en;
  endfunction

  function automatic logic [LEN_W-1:0] phase_len(input fd_cfg_t c, input logic ph);
    return ph ? eff_count(c.div_b) : eff_count(c.div_a);
  endfunction

  function automatic logic [LEN_W-1:0] phase_reps(input fd_cfg_t c, input logic ph);
    return ph ? eff_count(c.rep_b) : eff_count(c.rep_a);
  endfunction

  function automatic logic [REG_W-1:0] pack_word0(input fd_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[LO_LSB +: FIELD_W] = c.div_a;
    w[HI_LSB +: FIELD_W] = c.div_b;
    w[DUAL_BIT]          = c.dual;
    w[OEN_BIT]           = c.out_en;
    w[IEN_BIT]           = c.in_en;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] pack_word1(input fd_cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[LO_LSB +: FIELD_W] = c.rep_a;
    w[HI_LSB +: FIELD_W] = c.rep_b;
    w[BYP_BIT]           = c.bypass;
    return w;
  endfunction
endpackage

// File: rtl/fracdiv_regs.sv
module fracdiv_regs
  import fracdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_sel_i,
  output fd_cfg_t          cfg_o,
  output logic [REG_W-1:0] rd_data_o
);
  fd_cfg_t cfg_q, cfg_d;
  logic    locked;
  logic    unused_wr;

  assign locked    = cfg_running(cfg_q);
  assign unused_wr = ^{wr_data_i[29], wr_data_i[27:25]};

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) begin
      if (!wr_sel_i) begin
        cfg_d.in_en  = wr_data_i[IEN_BIT];
        cfg_d.out_en = wr_data_i[OEN_BIT];
        if (!locked) begin
          cfg_d.div_a = wr_data_i[LO_LSB +: FIELD_W];
          cfg_d.div_b = wr_data_i[HI_LSB +: FIELD_W];
          cfg_d.dual  = wr_data_i[DUAL_BIT];
        end
      end else if (!locked) begin
        cfg_d.rep_a  = wr_data_i[LO_LSB +: FIELD_W];
        cfg_d.rep_b  = wr_data_i[HI_LSB +: FIELD_W];
        cfg_d.bypass = wr_data_i[BYP_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o     = cfg_q;
  assign rd_data_o = rd_sel_i ? pack_word1(cfg_q) : pack_word0(cfg_q);
endmodule

// File: rtl/fracdiv_seq.sv
module fracdiv_seq
  import fracdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  fd_cfg_t            cfg_i,
  output logic               tick_o,
  output logic               running_o,
  output logic               phase_o,
  output logic [FIELD_W-1:0] cnt_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               period_end_o
);
  logic               phase_q, phase_d;
  logic [FIELD_W-1:0] cnt_q, cnt_d;
  logic [FIELD_W-1:0] per_q, per_d;
  logic [LEN_W-1:0]   cur_len, cur_reps;
  logic               running, last_cycle, last_period;

  assign running     = cfg_running(cfg_i);
  assign cur_len     = phase_len(cfg_i, phase_q);
  assign cur_reps    = phase_reps(cfg_i, phase_q);
  assign last_cycle  = ({1'b0, cnt_q} == cur_len - LEN_W'(1));
  assign last_period = ({1'b0, per_q} == cur_reps - LEN_W'(1));

  always_comb begin
    cnt_d   = cnt_q;
    per_d   = per_q;
    phase_d = phase_q;
    if (!running || cfg_i.bypass) begin
      cnt_d   = '0;
      per_d   = '0;
      phase_d = 1'b0;
    end else if (last_cycle) begin
      cnt_d = '0;
      if (!cfg_i.dual) begin
        per_d   = '0;
        phase_d = 1'b0;
      end else if (last_period) begin
        per_d   = '0;
        phase_d = ~phase_q;
      end else begin
        per_d = per_q + FIELD_W'(1);
      end
    end else begin
      cnt_d = cnt_q + FIELD_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      phase_q <= phase_d;
    end
  end

  assign tick_o       = running & (cfg_i.bypass | (cnt_q == '0));
  assign running_o    = running;
  assign phase_o      = phase_q;
  assign cnt_o        = cnt_q;
  assign len_o        = cur_len;
  assign period_end_o = running & ~cfg_i.bypass & last_cycle;
endmodule

// File: rtl/fracdiv_clkgen.sv
module fracdiv_clkgen
  import fracdiv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_sel_i,
  output logic [31:0] rd_data_o,
  output logic        tick_o
);
  fd_cfg_t            cfg_w;
  logic               run_w, phase_w, pend_w;
  logic [FIELD_W-1:0] cnt_w;
  logic [LEN_W-1:0]   len_w;

  fracdiv_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .cfg_o     (cfg_w),
    .rd_data_o (rd_data_o)
  );

  fracdiv_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg_w),
    .tick_o       (tick_o),
    .running_o    (run_w),
    .phase_o      (phase_w),
    .cnt_o        (cnt_w),
    .len_o        (len_w),
    .period_end_o (pend_w)
  );
endmodule

// File: rtl/fracdiv_chk.sv
module fracdiv_chk
  import fracdiv_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_o,
  input logic               running,
  input logic               phase_q,
  input logic [FIELD_W-1:0] cnt_q,
  input logic [LEN_W-1:0]   cur_len,
  input logic               period_end,
  input fd_cfg_t            cfg
);
  // R4
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !tick_o);
  // R4
  start_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running) |-> tick_o);
  // R5
  bypass_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && cfg.bypass) |-> tick_o);
  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running |-> ({1'b0, cnt_q} < cur_len));
  // R8
  phase_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && $past(running) && !$stable(phase_q)) |-> $past(period_end));
  // R6
  single_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !cfg.dual) |-> !phase_q);
  // R9
  word1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(running) |-> ($stable(cfg.rep_a) && $stable(cfg.rep_b) && $stable(cfg.bypass)));
endmodule

bind fracdiv_clkgen fracdiv_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_o     (tick_o),
  .running    (run_w),
  .phase_q    (phase_w),
  .cnt_q      (cnt_w),
  .cur_len    (len_w),
  .period_end (pend_w),
  .cfg        (cfg_w)
);

// File: tb/fracdiv_clkgen_test.sv
`timescale 1ns/1ps
module fracdiv_clkgen_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick;

  fracdiv_clkgen uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .tick_o(tick)
  );

  always #2.5 clk = ~clk;

  int    checks = 0, fails = 0;
  string tag = "R4";
  bit    cmp_en = 1'b0, done = 1'b0;

  // behavioural reference: a schedule of interval lengths
  logic [31:0] m0 = '0, m1 = '0;
  bit m_run = 1'b0;
  int m_wait = 0, m_idx = 0;

  function automatic int fld(input logic [31:0] w, input int lsb);
    return int'(w[lsb +: 12]) + 1;
  endfunction
  function automatic int seg_len(input int i);
    if (!m0[28]) return fld(m0, 0);
    return (i < fld(m1, 0)) ? fld(m0, 0) : fld(m0, 12);
  endfunction
  function automatic int seq_total();
    return m0[28] ? fld(m1, 0) + fld(m1, 12) : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m0 = '0; m1 = '0; m_run = 1'b0; m_wait = 0; m_idx = 0;
    end else begin
      if (m_run) begin
        if (m_wait == 0) begin
          m_wait = seg_len(m_idx) - 1;
          m_idx  = (m_idx + 1) % seq_total();
        end else m_wait = m_wait - 1;
      end
      if (wr_en) begin
        if (!wr_sel) begin
          if (m_run) m0[31:30] = wr_data[31:30];
          else       m0 = wr_data & 32'hD0FF_FFFF;
        end else if (!m_run) m1 = wr_data & 32'h01FF_FFFF;
      end
      if (m0[31] && m0[30] && !m_run) begin m_wait = 0; m_idx = 0; end
      m_run = m0[31] && m0[30];
    end
  end

  task automatic check(input bit ok, input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      logic exp_t;
      exp_t = m_run && (m1[24] || m_wait == 0);
      check(tick === exp_t, tag, "tick", {31'b0, tick}, {31'b0, exp_t});
    end
  end

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd_chk(input bit sel, input logic [31:0] exp, input string t);
    rd_sel = sel; #1;
    check(rd_data === exp, t, "readback", rd_data, exp);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic finish_up();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (R4 R7 sequence stalled)");
      finish_up();
    end
  end

  initial begin
    int cnt, g;
    idle(3);
    // reset state: R1 R2 R4
    check(tick === 1'b0, "R4", "reset tick", {31'b0, tick}, 0);
    rd_chk(0, 32'h0, "R1");
    rd_chk(1, 32'h0, "R2");
    rst_n = 1'b1;
    idle(2);
    cmp_en = 1'b1;

    // field layout with junk bits: R1 R2
    wr(1, 32'hFE00_2001);  rd_chk(1, 32'h0000_2001, "R2");
    wr(0, 32'h3F00_1002);  rd_chk(0, 32'h1000_1002, "R1");

    // dual mode small: N1=3 N2=2 M1=2 M2=3 : R7 R4
    tag = "R7";
    wr(0, 32'hD000_1002);
    #0.5 check(tick === 1'b1, "R4", "first tick", {31'b0, tick}, 1);
    idle(60);

    // lock while running: R9
    tag = "R9";
    wr(1, 32'h0100_0000);  rd_chk(1, 32'h0000_2001, "R9");
    wr(0, 32'hC0FF_FFFF);  rd_chk(0, 32'hD000_1002, "R9");
    idle(20);

    // restart mid second phase: R10
    tag = "R10";
    wr(0, 32'h1000_1002);
    idle(9);
    wr(0, 32'hD000_1002);
    g = 0;
    do begin @(negedge clk); g++; end while (!tick);
    check(g == 3, "R10", "first interval", g, 3);
    idle(30);

    // disabled states: R4
    tag = "R4";
    wr(0, 32'h1000_1002);  idle(10);
    wr(0, 32'h5000_1002);  idle(10);
    check(tick === 1'b0, "R4", "one enable only", {31'b0, tick}, 0);

    // single mode N1=5, N2 ignored: R6
    tag = "R6";
    wr(0, 32'h4000_7004);
    wr(0, 32'hC000_7004);  idle(40);

    // divider field 0: R3
    tag = "R3";
    wr(0, 32'h0000_0000);
    wr(0, 32'hC000_0000);  idle(10);
    check(tick === 1'b1, "R3", "divide by one", {31'b0, tick}, 1);

    // bypass over dual: R5
    tag = "R5";
    wr(0, 32'h0000_0000);
    wr(1, 32'h0100_2001);
    wr(0, 32'hD000_1002);  idle(10);
    check(tick === 1'b1, "R5", "bypass tick", {31'b0, tick}, 1);

    // typical setting, two full sequences: R8
    tag = "R8";
    wr(0, 32'h0000_0000);
    wr(1, 32'h0000_A007);
    wr(0, 32'h102D_B2DC);
    wr(0, 32'hD02D_B2DC);
    cnt = 0;
    repeat (27832) begin
      #0.5 if (tick) cnt++;
      @(negedge clk);
    end
    check(cnt == 38, "R8", "pulses in two sequences", cnt, 38);
    idle(5);
    cmp_en = 1'b0;
    finish_up();
  end
endmodule